// File: doc/BRIEF.md
# Reordering Memory Command Queue

This block is the command queue that sits between request arbitration and the command sequencer of a memory controller. Each incoming read or write carries a chip select, bank, row, column, source identifier and a two-bit priority. A new command is not simply appended. The queue computes an insertion slot and shifts the younger entries back by one to make room. Once an entry has been stored, the queue never changes its order relative to the other stored entries.

The slot is chosen by three rules, in this order of importance. First, a command must stay behind any queued command that targets the same chip select, bank and row. Second, it must stay behind any queued command of the same type that comes from the same source. Only after these two rules does priority decide: the command moves ahead of queued entries whose priority is strictly lower.

The oldest committed entry is offered on a valid/ready issue port. Two configuration inputs control the ordering. One disables reordering entirely, so the queue becomes a plain FIFO. The other disables only the same-address rule, for systems that guarantee coherency some other way.

Top module: `cmd_reorder_queue`

## Requirements
- R1: After reset the queue is empty: `q_empty`=1, `q_full`=0, `iss_valid`=0 and `req_ready`=1.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 exactly when 8 entries are held, and `q_full` is 1 in that case. A request offered while the queue is full is not stored.
- R3: `iss_valid` is 1 whenever at least one entry is held, and the issue fields show the front entry. That entry is removed on an edge where `iss_valid` and `iss_ready` are both 1.
- R4: While `iss_valid`=1 and `iss_ready`=0, the issue fields hold steady. A new command is never placed ahead of the entry already on the issue port, whatever its priority.
- R5: With `reorder_en`=0, every accepted command goes to the tail, and commands issue strictly in arrival order.
- R6: With `reorder_en`=1 and `addr_cmp_en`=1, a new command whose `cs`, `bank` and `row` all equal those of a queued entry is placed behind that entry, even when its priority is higher. This applies to reads and writes alike.
- R7: With `addr_cmp_en`=0, a matching `cs`/`bank`/`row` places no constraint on where a new command goes.
- R8: A new command with the same `write` bit and the same `src` as a queued entry is placed behind that entry. A matching `src` on a command of the other type places no constraint.
- R9: Priority 0 is the highest and 3 the lowest. Start from the first position after the last entry that R4, R6 or R8 forces the command behind. The command is inserted at the first position, from there on, whose entry has a numerically larger priority value. If no such position exists, the command goes to the tail. Equal priorities therefore keep arrival order.
- R10: An insertion shifts only the entries at and behind its slot, so entries already queued never change their order relative to each other.
- R11: An issue and an insertion on the same edge are both carried out. The slot is chosen from the contents before the issue, and the front entry leaves.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reorder_en | input | 1 | 1: rule-based insertion; 0: plain FIFO |
| addr_cmp_en | input | 1 | 1: same-address rule active |
| req_valid | input | 1 | New command offered |
| req_ready | output | 1 | Queue can take a command |
| req_write | input | 1 | 1 write, 0 read |
| req_cs | input | 2 | Chip select |
| req_bank | input | 3 | Bank |
| req_row | input | 14 | Row |
| req_col | input | 10 | Column |
| req_src | input | 4 | Source identifier |
| req_pri | input | 2 | Priority, 0 highest |
| iss_valid | output | 1 | Front entry available |
| iss_ready | input | 1 | Consumer takes the front entry |
| iss_write | output | 1 | Front entry type |
| iss_cs | output | 2 | Front entry chip select |
| iss_bank | output | 3 | Front entry bank |
| iss_row | output | 14 | Front entry row |
| iss_col | output | 10 | Front entry column |
| iss_src | output | 4 | Front entry source |
| iss_pri | output | 2 | Front entry priority |
| q_full | output | 1 | 8 entries held |
| q_empty | output | 1 | No entry held |

## Verification
The insertion rule is driven with several patterns, each chosen to separate one rule from the others:
- Mixed priorities in FIFO mode show that ordering is switched off.
- Distinct addresses and sources isolate the priority comparison, including ties.
- A high-priority command that shares a row with a low-priority one shows that the address fence overrides priority. The same stimulus with the compare disabled shows that the fence is gone.
- Same-source commands of equal and opposite type separate the source fence from the address fence.

A long run with narrow, colliding fields and random issue back-pressure then mixes insertions with issues on the same edge. A reference queue follows every step. In addition, every issued command is checked against all older outstanding commands, so that no guarded same-address pair ever leaves out of order.

// File: rtl/cmdq_pkg.sv
`timescale 1ns/1ps
package cmdq_pkg;
    parameter int CS_W   = 2;
    parameter int BANK_W = 3;
    parameter int ROW_W  = 14;
    parameter int COL_W  = 10;
    parameter int SRC_W  = 4;
    parameter int PRI_W  = 2;

    typedef struct packed {
        logic              wr;
        logic [CS_W-1:0]   cs;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [SRC_W-1:0]  src;
        logic [PRI_W-1:0]  pri;
    } cmd_t;

    typedef enum logic [1:0] {
        S_EMPTY   = 2'd0,
        S_PARTIAL = 2'd1,
        S_FULL    = 2'd2
    } qstate_e;

    // Same chip select, bank and row: ordering must be kept.
    function automatic logic same_page(cmd_t a, cmd_t b);
        return (a.cs == b.cs) && (a.bank == b.bank) && (a.row == b.row);
    endfunction

    // Same type from the same source: ordering must be kept.
    function automatic logic same_stream(cmd_t a, cmd_t b);
        return (a.wr == b.wr) && (a.src == b.src);
    endfunction
endpackage

// File: rtl/cmdq_slot_finder.sv
`timescale 1ns/1ps
module cmdq_slot_finder
    import cmdq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  cmd_t             ent [DEPTH],
    input  logic [CNT_W-1:0] count,
    input  cmd_t             new_cmd,
    input  logic             reorder_en,
    input  logic             addr_cmp_en,
    output logic [CNT_W-1:0] slot
);
    logic [DEPTH-1:0] fence;   // entry the new command must stay behind
    logic [DEPTH-1:0] weaker;  // entry with strictly lower priority
    logic [CNT_W-1:0] lo;
    logic             found;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        localparam logic [CNT_W-1:0] IC = CNT_W'(i);
        logic live;
        assign live      = IC < count;
        assign fence[i]  = live && ((addr_cmp_en && same_page(ent[i], new_cmd)) ||
                                    same_stream(ent[i], new_cmd));
        assign weaker[i] = live && (ent[i].pri > new_cmd.pri);
    end

    always_comb begin
        // The front entry is committed to the issue port: never insert ahead of it.
        lo = (count != '0) ? CNT_W'(1) : '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (fence[i]) lo = CNT_W'(i + 1);
        end
        slot  = count;
        found = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!found && weaker[i] && (CNT_W'(i) >= lo)) begin
                slot  = CNT_W'(i);
                found = 1'b1;
            end
        end
        if (!reorder_en) slot = count;
    end
endmodule

// File: rtl/cmdq_shift_store.sv
`timescale 1ns/1ps
module cmdq_shift_store
    import cmdq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins,
    input  logic             pop,
    input  logic [CNT_W-1:0] slot,
    input  cmd_t             new_cmd,
    output cmd_t             ent [DEPTH]
);
    for (genvar j = 0; j < DEPTH; j++) begin : g_pos
        localparam int PREV = (j > 0) ? j - 1 : 0;
        localparam int NEXT = (j < DEPTH - 1) ? j + 1 : j;
        localparam logic [CNT_W-1:0] JC = CNT_W'(j);
        localparam logic [CNT_W-1:0] JN = CNT_W'(j + 1);
        cmd_t r;
        cmd_t nxt;

        always_comb begin
            if (!pop) begin
                if (ins && slot == JC)                nxt = new_cmd;
                else if (ins && slot < JC)            nxt = ent[PREV];
                else                                  nxt = r;
            end else begin
                // Position j takes what would sit at j+1 before the pop.
                if (ins && slot == JN)                nxt = new_cmd;
                else if (ins && slot < JN)            nxt = r;
                else if (j < DEPTH - 1)               nxt = ent[NEXT];
                else                                  nxt = '0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          r <= '0;
            else if (ins || pop) r <= nxt;
        end

        assign ent[j] = r;
    end
endmodule

// File: rtl/cmd_reorder_queue.sv
`timescale 1ns/1ps
module cmd_reorder_queue
    import cmdq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reorder_en,
    input  logic              addr_cmp_en,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [CS_W-1:0]   req_cs,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [SRC_W-1:0]  req_src,
    input  logic [PRI_W-1:0]  req_pri,
    output logic              iss_valid,
    input  logic              iss_ready,
    output logic              iss_write,
    output logic [CS_W-1:0]   iss_cs,
    output logic [BANK_W-1:0] iss_bank,
    output logic [ROW_W-1:0]  iss_row,
    output logic [COL_W-1:0]  iss_col,
    output logic [SRC_W-1:0]  iss_src,
    output logic [PRI_W-1:0]  iss_pri,
    output logic              q_full,
    output logic              q_empty
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    qstate_e          state, state_n;
    logic [CNT_W-1:0] count, count_n, slot;
    logic             ins, pop;
    cmd_t             new_cmd, head;
    cmd_t             ent [DEPTH];

    assign new_cmd = '{wr: req_write, cs: req_cs, bank: req_bank, row: req_row,
                       col: req_col, src: req_src, pri: req_pri};
    assign ins     = req_valid && req_ready;
    assign pop     = iss_valid && iss_ready;
    assign count_n = count + CNT_W'(ins) - CNT_W'(pop);

    cmdq_slot_finder #(.DEPTH(DEPTH)) u_find (
        .ent(ent), .count(count), .new_cmd(new_cmd),
        .reorder_en(reorder_en), .addr_cmp_en(addr_cmp_en), .slot(slot)
    );

    cmdq_shift_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .ins(ins), .pop(pop),
        .slot(slot), .new_cmd(new_cmd), .ent(ent)
    );

    // State register and occupancy
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_EMPTY;
            count <= '0;
        end else begin
            state <= state_n;
            count <= count_n;
        end
    end

    // Transitions: FILL (empty->partial), TOP_OFF (partial->full),
    // DRAIN_LAST (partial->empty), RELEASE (full->partial)
    always_comb begin
        state_n = state;
        unique case (state)
            S_EMPTY:   if (ins) state_n = (count_n == FULL_CNT) ? S_FULL : S_PARTIAL;
            S_PARTIAL: begin
                if (count_n == '0)            state_n = S_EMPTY;
                else if (count_n == FULL_CNT) state_n = S_FULL;
            end
            S_FULL:    if (pop) state_n = (count_n == '0) ? S_EMPTY : S_PARTIAL;
            default:   state_n = S_EMPTY;
        endcase
    end

    // Outputs
    always_comb begin
        q_full  = 1'b0;
        q_empty = 1'b0;
        unique case (state)
            S_EMPTY:   q_empty = 1'b1;
            S_PARTIAL: ;
            S_FULL:    q_full  = 1'b1;
            default:   q_empty = 1'b1;
        endcase
        req_ready = !q_full;
        iss_valid = !q_empty;
    end

    assign head      = ent[0];
    assign iss_write = head.wr;
    assign iss_cs    = head.cs;
    assign iss_bank  = head.bank;
    assign iss_row   = head.row;
    assign iss_col   = head.col;
    assign iss_src   = head.src;
    assign iss_pri   = head.pri;
endmodule

// File: rtl/cmdq_checker.sv
`timescale 1ns/1ps
module cmdq_checker
    import cmdq_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic iss_valid,
    input logic iss_ready,
    input logic q_full,
    input logic q_empty,
    input cmd_t head
);
    p_empty_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (q_empty && !req_valid) |=> q_empty);

    p_full_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full && !iss_ready) |=> q_full);

    p_first_visible_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q_empty && req_valid && req_ready) |=> iss_valid);

    p_head_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_ready) |=> (iss_valid && $stable(head)));

    p_pop_frees_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full && iss_ready) |=> (!q_full && req_ready));
endmodule

bind cmd_reorder_queue cmdq_checker u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .q_full(q_full),
    .q_empty(q_empty), .head(head)
);

// File: tb/cmd_reorder_queue_tb.sv
`timescale 1ns/1ps
module cmd_reorder_queue_tb;
    import cmdq_pkg::*;
    localparam int DEPTH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;  // 50 MHz

    logic reorder_en = 1'b1, addr_cmp_en = 1'b1;
    logic req_valid = 1'b0, req_ready, req_write = 1'b0;
    logic [CS_W-1:0] req_cs = '0;
    logic [BANK_W-1:0] req_bank = '0;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic [SRC_W-1:0] req_src = '0;
    logic [PRI_W-1:0] req_pri = '0;
    logic iss_valid, iss_ready = 1'b0, iss_write;
    logic [CS_W-1:0] iss_cs;
    logic [BANK_W-1:0] iss_bank;
    logic [ROW_W-1:0] iss_row;
    logic [COL_W-1:0] iss_col;
    logic [SRC_W-1:0] iss_src;
    logic [PRI_W-1:0] iss_pri;
    logic q_full, q_empty;

    cmd_reorder_queue #(.DEPTH(DEPTH)) u_dut (.*);

    typedef struct {
        bit wr; int cs; int bank; int row; int col; int src; int pri; bit guard;
    } m_t;

    m_t    sb[$];       // expected queue order (scoreboard)
    m_t    arrived[$];  // outstanding commands in arrival order
    int    issued[$];
    int    checks = 0, errors = 0, next_col = 0, both_cnt = 0;
    bit    last_acc;
    string cur_tag = "R1";

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic bit same_page_m(m_t a, m_t b);
        return a.cs == b.cs && a.bank == b.bank && a.row == b.row;
    endfunction

    // Monitor: samples settled outputs between edges and advances the scoreboard.
    task automatic monitor();
        bit acc, pop, had, ok;
        int lo, slot, idx;
        m_t n;
        acc = req_valid && req_ready;
        pop = iss_valid && iss_ready;
        had = sb.size() > 0;
        check(req_ready == (sb.size() < DEPTH), "R2", "req_ready", req_ready, sb.size() < DEPTH);
        check(iss_valid == had, "R3", "iss_valid", iss_valid, had);
        if (had && iss_valid) begin
            check(int'(iss_col) == sb[0].col, cur_tag, "front col", iss_col, sb[0].col);
            check(int'(iss_pri) == sb[0].pri, cur_tag, "front pri", iss_pri, sb[0].pri);
        end
        if (pop && had) begin
            issued.push_back(int'(iss_col));
            idx = -1;
            foreach (arrived[i]) if (arrived[i].col == int'(iss_col)) idx = i;
            ok = idx >= 0;
            if (idx > 0)
                for (int i = 0; i < idx; i++)
                    if (arrived[idx].guard && same_page_m(arrived[i], arrived[idx])) ok = 0;
            check(ok, "R6", "same-address order kept at issue", iss_col, idx);
            if (idx >= 0) arrived.delete(idx);
        end
        if (acc) begin
            n = '{wr: req_write, cs: req_cs, bank: req_bank, row: req_row, col: next_col,
                  src: req_src, pri: req_pri, guard: addr_cmp_en && reorder_en};
            lo = had ? 1 : 0;
            slot = sb.size();
            if (reorder_en) begin
                foreach (sb[i])
                    if ((addr_cmp_en && same_page_m(sb[i], n)) ||
                        (sb[i].wr == n.wr && sb[i].src == n.src)) lo = i + 1;
                for (int i = lo; i < sb.size(); i++)
                    if (sb[i].pri > n.pri) begin slot = i; break; end
            end
            sb.insert(slot, n);
            arrived.push_back(n);
            next_col++;
        end
        if (pop && had) void'(sb.pop_front());
        if (acc && pop) both_cnt++;
        last_acc = acc;
    endtask

    task automatic step();
        #1 monitor();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send(bit wr, int cs, int bank, int row, int src, int pri);
        req_valid = 1'b1; req_write = wr;
        req_cs = CS_W'(cs); req_bank = BANK_W'(bank); req_row = ROW_W'(row);
        req_src = SRC_W'(src); req_pri = PRI_W'(pri); req_col = COL_W'(next_col);
        for (int k = 0; k < 50; k++) begin
            step();
            if (last_acc) break;
        end
        req_valid = 1'b0;
    endtask

    task automatic drain();
        iss_ready = 1'b1;
        for (int k = 0; k < 40 && sb.size() > 0; k++) step();
        iss_ready = 1'b0;
        step();
    endtask

    task automatic expect_order(string tag, int exp[$]);
        check(issued.size() == exp.size(), tag, "issued count", issued.size(), exp.size());
        foreach (exp[i])
            if (i < issued.size())
                check(issued[i] == exp[i], tag, "issue order col", issued[i], exp[i]);
        issued.delete();
    endtask

    initial begin
        #3000000;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state
        check(q_empty == 1'b1, "R1", "q_empty", q_empty, 1);
        check(q_full == 1'b0, "R1", "q_full", q_full, 0);
        check(iss_valid == 1'b0, "R1", "iss_valid", iss_valid, 0);
        check(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
        @(negedge clk);

        // R5 FIFO mode with mixed priorities, R2 fill and refused request
        cur_tag = "R5"; reorder_en = 1'b0; issued.delete(); b = next_col;
        begin
            int pr[8] = '{3, 0, 2, 1, 0, 3, 1, 2};
            foreach (pr[i]) send(1'b0, 0, i, 10 + i, i, pr[i]);
        end
        #1 check(q_full == 1'b1, "R2", "q_full after 8", q_full, 1);
        @(negedge clk);
        req_valid = 1'b1; req_pri = '0; req_col = COL_W'(next_col);
        repeat (3) step();
        req_valid = 1'b0;
        #1 check(q_full == 1'b1, "R2", "still full after refused request", q_full, 1);
        @(negedge clk);
        drain();
        expect_order("R5", '{b, b+1, b+2, b+3, b+4, b+5, b+6, b+7});

        // R9 priority with ties, R4 front held
        cur_tag = "R9"; reorder_en = 1'b1; b = next_col;
        send(1'b0, 1, 0, 100, 1, 1);
        send(1'b0, 1, 1, 101, 2, 3);
        send(1'b0, 1, 2, 102, 3, 2);
        send(1'b0, 1, 3, 103, 4, 0);
        send(1'b0, 1, 4, 104, 5, 2);
        #1 check(int'(iss_col) == b, "R4", "front not displaced by priority 0", iss_col, b);
        @(negedge clk);
        drain();
        expect_order("R9", '{b, b+3, b+2, b+4, b+1});

        // R6 address fence beats priority
        cur_tag = "R6"; b = next_col;
        send(1'b0, 0, 0, 9, 1, 0);
        send(1'b0, 2, 5, 5, 2, 3);
        send(1'b0, 2, 5, 6, 3, 3);
        send(1'b1, 2, 5, 5, 4, 0);
        drain();
        expect_order("R6", '{b, b+1, b+3, b+2});

        // R7 same stimulus, compare disabled
        cur_tag = "R7"; addr_cmp_en = 1'b0; b = next_col;
        send(1'b0, 0, 0, 9, 1, 0);
        send(1'b0, 2, 5, 5, 2, 3);
        send(1'b0, 2, 5, 6, 3, 3);
        send(1'b1, 2, 5, 5, 4, 0);
        drain();
        expect_order("R7", '{b, b+3, b+1, b+2});
        addr_cmp_en = 1'b1;

        // R8 same source: same type fenced, other type free
        cur_tag = "R8"; b = next_col;
        send(1'b0, 0, 0, 200, 9, 0);
        send(1'b0, 0, 1, 201, 5, 3);
        send(1'b0, 0, 2, 202, 6, 3);
        send(1'b0, 0, 3, 203, 5, 0);
        send(1'b1, 0, 4, 204, 5, 0);
        drain();
        expect_order("R8", '{b, b+4, b+1, b+3, b+2});

        // R10 / R11 random mix with colliding fields and simultaneous issue
        cur_tag = "R10"; both_cnt = 0;
        for (int c = 0; c < 600; c++) begin
            req_valid = ($urandom_range(0, 2) != 0);
            req_write = 1'($urandom_range(0, 1));
            req_cs = CS_W'($urandom_range(0, 1));
            req_bank = BANK_W'($urandom_range(0, 1));
            req_row = ROW_W'($urandom_range(0, 3));
            req_src = SRC_W'($urandom_range(0, 3));
            req_pri = PRI_W'($urandom_range(0, 3));
            req_col = COL_W'(next_col);
            iss_ready = ($urandom_range(0, 2) == 0);
            reorder_en = 1'b1;
            step();
        end
        req_valid = 1'b0;
        drain();
        issued.delete();
        check(both_cnt > 0, "R11", "edges with issue and insert", both_cnt, 1);
        #1 check(q_empty == 1'b1, "R11", "empty after drain", q_empty, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule